// File: doc/BRIEF.md
# Sequential Configuration Register Loader (I2C Write Slave)

This block is an I2C target that only accepts writes. It loads a bank of nine 8-bit configuration registers. It runs on a system clock that oversamples the bus. It passes SCL and SDA through synchronizers and finds bus edges, START and STOP in those samples. For acknowledges it drives one output that enables an external pull-down on SDA.

The protocol has no register-address byte. After the master sends a matching 7-bit address with the write bit, every data byte goes into the next register in the bank. The first data byte always lands in register 0 and the bytes then follow in ascending index order. Each START resets this pointer. The lowest address bit comes from a select pin on the board, so two of these targets can share a bus. Every register update comes with a one-cycle strobe, so the logic downstream can react to a new setting.

Top module: `i2c_seq_cfg_slave`

## Requirements
- R1: The target answers to the 7-bit address binary 001000A, where A is the level on `addrSel`. It acknowledges the address byte (address in bits 7..1, MSB first, direction in bit 0) only when the address matches and the direction bit is 0 (write).
- R2: An acknowledge is given by driving `sdaPullDown` high. This starts after the SCL falling edge that closes the eighth bit and ends after the SCL falling edge that closes the ninth clock. `sdaPullDown` changes only while SCL is low, and it is never high during the eight data-bit clocks.
- R3: After an acknowledged write address, data bytes are received MSB first. Data byte k (k = 0..8) is written to register k, which is bits [8k+7:8k] of `cfgRegs`, and it is acknowledged.
- R4: Each register write pulses `cfgWrStb[k]` for exactly one system clock. This happens in the same cycle that the new value first appears on `cfgRegs`. At most one strobe bit is high at a time. A register never changes without its strobe.
- R5: A data byte that arrives after nine bytes in the same transfer is not acknowledged and changes no register.
- R6: After a non-matching address or a read request, the target gives no acknowledge and changes no register until the next START or STOP.
- R7: A repeated START ends the current transfer and discards any partly received byte. It then begins address reception again with the register pointer back at register 0.
- R8: A STOP (SDA rising while SCL is high) ends the transfer. Bus clocks that follow without a START get no acknowledge and change nothing.
- R9: A synchronous reset sets every register to 0x00, clears all strobes and `sdaPullDown`, and returns the receiver to idle.
- R10: Transfers work correctly with an SCL period of 21 system clocks (about 11 clocks low and 10 clocks high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level (wired-AND bus value) |
| addrSel | input | 1 | Level used as the address LSB |
| sdaPullDown | output | 1 | When high, SDA is pulled low (acknowledge) |
| cfgRegs | output | NUM_REGS*BYTE_W | Register bank, register k in bits [8k+7:8k] |
| cfgWrStb | output | NUM_REGS | One-cycle write strobe per register |

## Verification
A bus edge reaches the control logic after two synchronizer flops and one edge-detect flop, about three system clocks after the pin moves. A register and its strobe update one clock after the eighth rising SCL edge is detected. `sdaPullDown` moves one clock after a falling SCL edge is detected, so it settles roughly three to four clocks after the pin falls. The bench drives SDA five clocks into each low phase. It samples the acknowledge five clocks into the high phase of the ninth clock and compares the register bank only after that ninth clock has ended. Every result is therefore sampled at least five clocks after it is due. Strobes are counted on every falling system clock edge and compared with the number of writes the model expects.

// File: rtl/seqcfg_pkg.sv
package seqcfg_pkg;

  // Strobes from the bus control to the datapath
  typedef struct packed {
    logic shiftBit;    // shift the sampled SDA bit into the byte register
    logic clearPtr;    // START seen: register pointer back to 0
    logic commitByte;  // eighth data bit received: write the byte
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_DATA,
    ST_IGNORE
  } rxState_e;

endpackage

// File: rtl/seqcfg_sync.sv
module seqcfg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/seqcfg_ctrl.sv
module seqcfg_ctrl
  import seqcfg_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   sclRaw,
  input  logic   sdaRaw,
  input  logic   addrMatchNext,
  input  logic   bankFull,
  output dpCmd_t dpCmd,
  output logic   sdaSample,
  output logic   sdaPullDown
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;

  rxState_e state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic pullNext;
  logic lastBit;

  seqcfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSclSync (
    .clk(clk), .rst(rst), .din(sclRaw), .dout(sclS)
  );
  seqcfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSdaSync (
    .clk(clk), .rst(rst), .din(sdaRaw), .dout(sdaS)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise   =  sclS & ~sclPrev;
  assign sclFall   = ~sclS &  sclPrev;
  assign startCond =  sclS &  sclPrev &  sdaPrev & ~sdaS;
  assign stopCond  =  sclS &  sclPrev & ~sdaPrev &  sdaS;
  assign lastBit   = (bitCnt == LAST_BIT);
  assign sdaSample = sdaS;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    pullNext   = sdaPullDown;
    dpCmd      = '0;
    if (startCond) begin
      stateNext      = ST_ADDR;
      bitCntNext     = '0;
      pullNext       = 1'b0;
      dpCmd.clearPtr = 1'b1;
    end else if (stopCond) begin
      stateNext  = ST_IDLE;
      bitCntNext = '0;
      pullNext   = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) begin
            dpCmd.shiftBit = 1'b1;
            if (lastBit) begin
              bitCntNext = '0;
              stateNext  = addrMatchNext ? ST_ACK_WAIT : ST_IGNORE;
            end else begin
              bitCntNext = bitCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sclRise) begin
            dpCmd.shiftBit = 1'b1;
            if (lastBit) begin
              bitCntNext = '0;
              if (!bankFull) begin
                dpCmd.commitByte = 1'b1;
                stateNext        = ST_ACK_WAIT;
              end else begin
                stateNext = ST_IGNORE;
              end
            end else begin
              bitCntNext = bitCnt + 1'b1;
            end
          end
        end
        ST_ACK_WAIT: begin
          if (sclFall) begin
            pullNext  = 1'b1;
            stateNext = ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (sclFall) begin
            pullNext  = 1'b0;
            stateNext = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      sdaPullDown <= 1'b0;
    end else begin
      state       <= stateNext;
      bitCnt      <= bitCntNext;
      sdaPullDown <= pullNext;
    end
  end

endmodule

// File: rtl/seqcfg_dp.sv
module seqcfg_dp
  import seqcfg_pkg::*;
#(
  parameter int               NUM_REGS    = 9,
  parameter int               BYTE_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [BYTE_W-3:0] ADDR_HI    = 6'b001000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpCmd_t                     dpCmd,
  input  logic                       sdaSample,
  input  logic                       addrSelRaw,
  output logic                       addrMatchNext,
  output logic                       bankFull,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  output logic [NUM_REGS-1:0]        cfgWrStb
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);

  logic [BYTE_W-2:0] shReg;
  logic [BYTE_W-1:0] byteNext;
  logic [PTR_W-1:0]  ptr;
  logic              addrSelS;

  seqcfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSelSync (
    .clk(clk), .rst(rst), .din(addrSelRaw), .dout(addrSelS)
  );

  assign byteNext      = {shReg, sdaSample};
  assign addrMatchNext = (byteNext[BYTE_W-1:1] == {ADDR_HI, addrSelS}) && !byteNext[0];
  assign bankFull      = (ptr == PTR_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst)                 shReg <= '0;
    else if (dpCmd.shiftBit) shReg <= byteNext[BYTE_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                   ptr <= '0;
    else if (dpCmd.clearPtr)   ptr <= '0;
    else if (dpCmd.commitByte) ptr <= ptr + 1'b1;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : gReg
    logic hit;
    assign hit = dpCmd.commitByte && (ptr == PTR_W'(k));
    always_ff @(posedge clk) begin
      if (rst) begin
        cfgRegs[k*BYTE_W +: BYTE_W] <= '0;
        cfgWrStb[k]                 <= 1'b0;
      end else begin
        cfgWrStb[k] <= hit;
        if (hit) cfgRegs[k*BYTE_W +: BYTE_W] <= byteNext;
      end
    end
  end

endmodule

// File: rtl/i2c_seq_cfg_slave.sv
module i2c_seq_cfg_slave
  import seqcfg_pkg::*;
#(
  parameter int                NUM_REGS    = 9,
  parameter int                BYTE_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-3:0] ADDR_HI     = 6'b001000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic                       addrSel,
  output logic                       sdaPullDown,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  output logic [NUM_REGS-1:0]        cfgWrStb
);

  dpCmd_t dpCmd;
  logic   sdaSample, addrMatchNext, bankFull;

  seqcfg_ctrl #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .addrMatchNext(addrMatchNext), .bankFull(bankFull),
    .dpCmd(dpCmd), .sdaSample(sdaSample), .sdaPullDown(sdaPullDown)
  );

  seqcfg_dp #(
    .NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W),
    .SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI)
  ) uDp (
    .clk(clk), .rst(rst), .dpCmd(dpCmd), .sdaSample(sdaSample),
    .addrSelRaw(addrSel), .addrMatchNext(addrMatchNext), .bankFull(bankFull),
    .cfgRegs(cfgRegs), .cfgWrStb(cfgWrStb)
  );

endmodule

// File: rtl/seqcfg_checker.sv
module seqcfg_checker #(
  parameter int NUM_REGS = 9,
  parameter int BYTE_W   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sclIn,
  input logic                       sdaPullDown,
  input logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  input logic [NUM_REGS-1:0]        cfgWrStb
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (rst) pastValid <= 1'b0;
    else     pastValid <= 1'b1;
  end

  // R4: never two strobes at once
  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cfgWrStb));

  // R4: a register only changes together with its own strobe
  for (genvar k = 0; k < NUM_REGS; k++) begin : gChk
    p_change_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
      (pastValid && (cfgRegs[k*BYTE_W +: BYTE_W] != $past(cfgRegs[k*BYTE_W +: BYTE_W])))
        |-> cfgWrStb[k]);
  end

  // R2: the acknowledge drive moves only while the bus clock is low
  p_ack_moves_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$stable(sdaPullDown)) |-> !sclIn);

  // R9: reset clears the bank, the strobes and the pull-down
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (cfgRegs == '0 && cfgWrStb == '0 && !sdaPullDown));

endmodule

bind i2c_seq_cfg_slave seqcfg_checker #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) uChk (
  .clk(clk), .rst(rst), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .cfgRegs(cfgRegs), .cfgWrStb(cfgWrStb)
);

// File: tb/tb_i2c_seq_cfg_slave.sv
module tb_i2c_seq_cfg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic addrSel = 1'b0;
  logic sdaPullDown;
  logic [NREG*8-1:0] cfgRegs;
  logic [NREG-1:0] cfgWrStb;
  logic sdaBus;

  assign sdaBus = sdaDrv & ~sdaPullDown;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_seq_cfg_slave dut (
    .clk(clk), .rst(rst), .sclIn(sclDrv), .sdaIn(sdaBus), .addrSel(addrSel),
    .sdaPullDown(sdaPullDown), .cfgRegs(cfgRegs), .cfgWrStb(cfgWrStb)
  );

  int nChecks = 0;
  int nFail = 0;
  int strbCnt [NREG];
  int expStb [NREG];
  int multiStb = 0;
  int pullInData = 0;
  logic [NREG*8-1:0] expFlat = '0;
  int expPtr = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(cfgWrStb) > 1) multiStb++;
      for (int i = 0; i < NREG; i++) if (cfgWrStb[i]) strbCnt[i]++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclDrv) begin
      waitClk(5); sdaDrv = 1'b1; waitClk(6); sclDrv = 1'b1; waitClk(5);
    end else begin
      waitClk(5);
    end
    sdaDrv = 1'b0; waitClk(10); sclDrv = 1'b0;
  endtask

  task automatic busStop();
    waitClk(5); sdaDrv = 1'b0; waitClk(6); sclDrv = 1'b1; waitClk(10); sdaDrv = 1'b1; waitClk(10);
  endtask

  // R10: 11 clocks low, 10 clocks high, 21-clock period
  task automatic sendBit(input logic b);
    waitClk(5); sdaDrv = b; waitClk(6); sclDrv = 1'b1;
    waitClk(5); if (sdaPullDown) pullInData++;
    waitClk(5); sclDrv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    waitClk(5); sdaDrv = 1'b1; waitClk(6); sclDrv = 1'b1;
    waitClk(5); acked = !sdaBus;
    waitClk(5); sclDrv = 1'b0;
  endtask

  task automatic doTxn(input logic [6:0] addr, input logic rw, input int nBytes,
                       input bit endStop, output int ackCnt);
    logic ack;
    logic addrOk;
    logic expAck;
    logic [7:0] b;
    string tag;
    ackCnt = 0;
    busStart();
    expPtr = 0;
    addrOk = (addr == {6'b001000, addrSel}) && !rw;
    sendByte({addr, rw}, ack);
    check(ack == addrOk, addrOk ? "R1 address ack" : "R6 address nack", ack, addrOk);
    for (int k = 0; k < nBytes; k++) begin
      b = 8'($urandom);
      sendByte(b, ack);
      expAck = addrOk && (expPtr < NREG);
      tag = !addrOk ? "R6 ignored data" : (expPtr >= NREG ? "R5 overflow byte" : "R3 data byte");
      check(ack == expAck, tag, ack, expAck);
      if (expAck) begin
        expFlat[expPtr*8 +: 8] = b;
        expStb[expPtr]++;
        expPtr++;
        ackCnt++;
      end
      check(cfgRegs == expFlat, tag, cfgRegs, expFlat);
    end
    if (endStop) busStop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int acks;
    int seedInit;
    logic ack;
    logic [6:0] a;
    seedInit = $urandom(32'd20240611);
    for (int i = 0; i < NREG; i++) begin strbCnt[i] = 0; expStb[i] = 0; end

    waitClk(6);
    check(cfgRegs == '0 && cfgWrStb == '0 && !sdaPullDown, "R9 reset state",
          {cfgRegs, cfgWrStb, sdaPullDown}, '0);
    rst = 1'b0;
    waitClk(10);

    // full bank at the nominal bus rate
    doTxn(7'b0010000, 1'b0, 9, 1'b1, acks);
    check(acks == 9, "R10 nine bytes acknowledged", acks, 9);

    // overflow: bytes ten and eleven refused
    doTxn(7'b0010000, 1'b0, 11, 1'b1, acks);
    check(acks == 9, "R5 only nine accepted", acks, 9);

    // select pin high: other address now matches
    addrSel = 1'b1; waitClk(10);
    doTxn(7'b0010000, 1'b0, 2, 1'b1, acks);
    check(acks == 0, "R1 old address ignored", acks, 0);
    doTxn(7'b0010001, 1'b0, 3, 1'b1, acks);
    check(acks == 3, "R1 new address accepted", acks, 3);

    // read request ignored
    doTxn(7'b0010001, 1'b1, 2, 1'b1, acks);
    check(acks == 0, "R6 read ignored", acks, 0);

    // repeated START: partial byte dropped, pointer restarts
    doTxn(7'b0010001, 1'b0, 2, 1'b0, acks);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    doTxn(7'b0010001, 1'b0, 1, 1'b1, acks);
    check(acks == 1 && cfgRegs == expFlat, "R7 restart to register 0", cfgRegs, expFlat);

    // clocks after STOP with no START
    waitClk(5); sclDrv = 1'b0;
    sendByte(8'h22, ack);
    check(!ack, "R8 no ack after stop", ack, 0);
    check(cfgRegs == expFlat, "R8 bank unchanged after stop", cfgRegs, expFlat);
    busStop();

    // random transfers
    for (int t = 0; t < 30; t++) begin
      int sel;
      bit stopIt;
      sel = int'($urandom % 4);
      if (sel == 2) begin
        a = 7'($urandom);
        if (a[6:1] == 6'b001000) a ^= 7'h40;
      end else begin
        a = {6'b001000, addrSel};
      end
      stopIt = ($urandom % 4) != 0;
      doTxn(a, sel == 3, int'($urandom % 12), stopIt, acks);
      if (stopIt && ($urandom % 3 == 0)) begin
        addrSel = ~addrSel; waitClk(10);
      end
    end
    if (!sclDrv) busStop();

    waitClk(5);
    for (int i = 0; i < NREG; i++)
      check(strbCnt[i] == expStb[i], "R4 strobe count", strbCnt[i], expStb[i]);
    check(multiStb == 0, "R4 strobes one-hot", multiStb, 0);
    check(pullInData == 0, "R2 no pull-down during data bits", pullInData, 0);

    // reset in mid-life clears the bank
    @(negedge clk); rst = 1'b1; waitClk(3);
    check(cfgRegs == '0 && !sdaPullDown, "R9 reset clears bank", cfgRegs, '0);
    rst = 1'b0; expFlat = '0; waitClk(10);
    doTxn({6'b001000, addrSel}, 1'b0, 1, 1'b1, acks);
    check(acks == 1, "R9 usable after reset", acks, 1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule